// File: doc/BRIEF.md
# Prescaled Interval Timer Channel

This block is a single channel of a down-counting interval timer. Software programs it through a small word-addressed register port: a control word, an interval value, a read-only live count, and a status word. The control word selects which of several tick sources clocks the timer and sets a power-of-two prescale divider. It also holds an enable bit and a reload request.

Each tick source arrives as a one-cycle enable pulse that is already synchronous to the system clock. The selected pulses pass through a free-running prescaler, and its scaled ticks decrement the counter. When a scaled tick finds the counter at zero, the channel reloads the interval and emits a one-cycle interrupt pulse. The power-on control encoding already selects the fast source with no division, so the channel runs from the moment it is enabled. Selecting the undefined source stops all ticks and latches an error flag that software can read.

Top module: `tick_timer_channel`

## Requirements
- R1: After reset, control reads 0x4 (source 1, divide by 1, reload and enable clear), and interval, count, error flag and irq_o are all 0.
- R2: Register addresses: 0 is control (7 bits; read bits 31:7 are 0), 1 is interval (32 bits), 2 is the live counter (read only, writes are ignored), 3 is status with the sticky error flag at bit 0.
- R3: A control write with bit 1 set loads the current interval value into the counter; the loaded value reads back in the cycle after the write.
- R4: Control bits [3:2] select the tick source: 0 uses src_tick_i[0], 1 uses src_tick_i[1], 2 uses src_tick_i[2]; ticks on unselected sources have no effect.
- R5: Control bits [6:4] hold n, and the counter receives one scaled tick for every 2^n selected source ticks (divide by 1 up to 128).
- R6: Every control write clears the prescaler, so the first scaled tick after it comes a full 2^n selected ticks later.
- R7: Control bit 0 enables counting; while it is 0 the counter holds its value.
- R8: A scaled tick while enabled and while the counter is 0 reloads the counter from interval and raises irq_o for exactly one cycle, in the cycle after the tick. Otherwise the counter decrements by 1.
- R9: Source code 3 produces no ticks, so the counter stays frozen. While it is selected, status bit 0 is set and stays set until software writes 1 to status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick_i | input | 3 | One-cycle tick enables, one per source |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word address for both read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | One-cycle underflow interrupt pulse |

## Verification
The case hardest to reach from the ports is the prescaler's phase. It cannot be read back, so the bench shows that a control write clears it indirectly. The bench first advances the prescaler partway through a divide-by-4 period and then rewrites control. It then shows that the counter holds for three further ticks and moves only on the fourth. The bench also drives a full divide-by-128 period and checks the count on the tick before the last and on the last. It forces an underflow and checks the reloaded count and the single interrupt pulse.

// File: rtl/tmr_pkg.sv
// Package: shared constants and control-word layout for the timer channel.
// Assumes a 7-bit control word: prescale exponent, source, reload, enable.
package tmr_pkg;
    localparam int PSC_FW  = 3;                 // prescale exponent width
    localparam int SRC_FW  = 2;                 // source select width
    localparam int PDIV_W  = (1 << PSC_FW) - 1; // prescaler counter width
    localparam int CTRL_W  = PSC_FW + SRC_FW + 2;

    typedef struct packed {
        logic [PSC_FW-1:0] psc;
        logic [SRC_FW-1:0] src;
        logic              reload;
        logic              en;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{psc: '0, src: 2'd1, reload: 1'b0, en: 1'b0};

    localparam logic [1:0] A_CTRL   = 2'd0;
    localparam logic [1:0] A_IVAL   = 2'd1;
    localparam logic [1:0] A_COUNT  = 2'd2;
    localparam logic [1:0] A_STATUS = 2'd3;
endpackage

// File: rtl/tmr_src_mux.sv
// Module: picks one source tick from the select field.
// Assumes ticks are single-cycle and synchronous; codes at or above NUM_SRC give no tick.
module tmr_src_mux
    import tmr_pkg::*;
#(
    parameter int NUM_SRC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] tick_i,
    input  logic [SRC_FW-1:0] sel_i,
    output logic              tick_o
);
    localparam int NSLOT = 1 << SRC_FW;

    logic [NSLOT-1:0] slot;

    // Purpose: pad the source vector so every select code maps to a slot.
    generate
        for (genvar g = 0; g < NSLOT; g++) begin : g_slot
            if (g < NUM_SRC) begin : g_live
                assign slot[g] = tick_i[g];
            end else begin : g_dead
                assign slot[g] = 1'b0;
            end
        end
    endgenerate

    // Purpose: route the selected slot to the output.
    always_comb tick_o = slot[sel_i];

    a_r9_no_tick_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel_i) >= NUM_SRC) |-> !tick_o);
    a_r4_follow_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel_i) < NUM_SRC && tick_i[sel_i]) |-> tick_o);
endmodule

// File: rtl/tmr_prescaler.sv
// Module: free-running power-of-two prescaler on the selected tick.
// Emits a scaled tick when the low n bits of the advanced count wrap to zero.
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              tick_i,
    input  logic [PSC_FW-1:0] exp_i,
    output logic              scaled_o
);
    logic [PDIV_W-1:0] cnt_q;
    logic [PDIV_W-1:0] cnt_nxt;
    logic [PDIV_W-1:0] mask;

    // Purpose: next count value and the wrap mask for the chosen exponent.
    always_comb begin
        cnt_nxt = cnt_q + PDIV_W'(1);
        mask    = PDIV_W'(({1'b0, {PDIV_W{1'b0}}} | (PDIV_W+1)'(1) << exp_i) - (PDIV_W+1)'(1));
    end

    // Purpose: advance on each selected tick, clear on reconfiguration.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) cnt_q <= '0;
        else if (tick_i)     cnt_q <= cnt_nxt;
    end

    // Purpose: scaled tick when the masked bits wrap.
    always_comb scaled_o = tick_i && !clr_i && ((cnt_nxt & mask) == '0);

    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));
    a_r5_div1_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_i == '0 && tick_i && !clr_i) |-> scaled_o);
    a_r5_no_tick_no_scaled: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |-> !scaled_o);
endmodule

// File: rtl/tmr_down_counter.sv
// Module: down counter with load, reload on underflow and an interrupt pulse.
// Assumes load and tick are single-cycle strobes; load takes priority.
module tmr_down_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] ival_i,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o
);
    logic step;

    // Purpose: a count step happens on an enabled scaled tick.
    always_comb step = en_i && tick_i && !load_i;

    // Purpose: load, reload on underflow, or decrement the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
            irq_o   <= 1'b0;
        end else begin
            irq_o <= 1'b0;
            if (load_i) begin
                count_o <= ival_i;
            end else if (step) begin
                if (count_o == '0) begin
                    count_o <= ival_i;
                    irq_o   <= 1'b1;
                end else begin
                    count_o <= count_o - CNT_W'(1);
                end
            end
        end
    end

    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_o == $past(ival_i) && !irq_o));
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !(en_i && tick_i)) |=> ($stable(count_o) && !irq_o));
    a_r8_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tick_i && !load_i && count_o != '0) |=> (count_o == $past(count_o) - CNT_W'(1)));
    a_r8_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tick_i && !load_i && count_o == '0) |=> (irq_o && count_o == $past(ival_i)));
endmodule

// File: rtl/tick_timer_channel.sv
// Module: one interval timer channel with register port, source select and prescaler.
// Assumes source ticks are synchronous single-cycle enables; reads are combinational.
module tick_timer_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick_i,
    input  logic               wr_en_i,
    input  logic [1:0]         addr_i,
    input  logic [31:0]        wdata_i,
    output logic [31:0]        rdata_o,
    output logic               irq_o
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] ival_q;
    logic [CNT_W-1:0] count;
    logic             err_q;
    logic             ctrl_wr;
    logic             err_clr;
    logic             sel_tick;
    logic             scaled;

    // Purpose: decode register write strobes.
    always_comb begin
        ctrl_wr = wr_en_i && (addr_i == A_CTRL);
        err_clr = wr_en_i && (addr_i == A_STATUS) && wdata_i[0];
    end

    // Purpose: hold the control and interval registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            ival_q <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
            if (wr_en_i && addr_i == A_IVAL) ival_q <= wdata_i[CNT_W-1:0];
        end
    end

    // Purpose: sticky flag for the undefined source, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                         err_q <= 1'b0;
        else if (err_clr)                   err_q <= 1'b0;
        else if (int'(ctrl_q.src) >= NUM_SRC) err_q <= 1'b1;
    end

    tmr_src_mux #(.NUM_SRC(NUM_SRC)) i_mux (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (src_tick_i),
        .sel_i  (ctrl_q.src),
        .tick_o (sel_tick)
    );

    tmr_prescaler i_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (ctrl_wr),
        .tick_i   (sel_tick),
        .exp_i    (ctrl_q.psc),
        .scaled_o (scaled)
    );

    tmr_down_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (ctrl_q.en),
        .tick_i  (scaled),
        .load_i  (ctrl_wr && wdata_i[1]),
        .ival_i  (ival_q),
        .count_o (count),
        .irq_o   (irq_o)
    );

    // Purpose: read multiplexer over the four registers.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTRL:   rdata_o[CTRL_W-1:0] = ctrl_q;
            A_IVAL:   rdata_o[CNT_W-1:0]  = ival_q;
            A_COUNT:  rdata_o[CNT_W-1:0]  = count;
            default:  rdata_o[0]          = err_q;
        endcase
    end

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !err_clr) |=> err_q);
    a_r2_count_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == A_COUNT && !sel_tick) |=> $stable(count));
    a_r1_ctrl_default: assert property (@(posedge clk)
        !rst_n |=> (ctrl_q == CTRL_RST && err_q == 1'b0));
endmodule

// File: tb/test_tick_timer_channel.sv
`timescale 1ns/1ps
module test_tick_timer_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  src_tick_i = '0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    int irq_cnt = 0;
    bit finished = 0;

    typedef struct {
        int          kind;   // 0: compare rdata_o, 1: compare irq count
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];
    event done_ev;

    always #2 clk = ~clk;

    tick_timer_channel i_tick_timer_channel (
        .clk(clk), .rst_n(rst_n), .src_tick_i(src_tick_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    // Monitor: count interrupt pulses away from the active edge.
    always @(negedge clk) if (rst_n && irq_o) irq_cnt++;

    // Monitor: pop expected items and compare with what the design shows.
    initial forever begin
        item_t it;
        logic [31:0] act;
        wait (sb.size() != 0);
        #1;
        it = sb.pop_front();
        act = (it.kind == 0) ? rdata_o : 32'(irq_cnt);
        n_chk++;
        if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
        end
        -> done_ev;
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic pulse(input int s, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            src_tick_i = 3'b001 << s;
            @(negedge clk);
            src_tick_i = '0;
        end
    endtask

    task automatic exp_rd(input logic [1:0] a, input logic [31:0] e, input string t);
        addr_i = a;
        sb.push_back('{0, e, t});
        @(done_ev);
    endtask

    task automatic exp_irq(input int e, input string t);
        sb.push_back('{1, 32'(e), t});
        @(done_ev);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        exp_rd(2'd0, 32'h4, "R1 ctrl default");
        exp_rd(2'd1, 32'h0, "R1 interval");
        exp_rd(2'd2, 32'h0, "R1 count");
        exp_rd(2'd3, 32'h0, "R1 err flag");
        exp_irq(0, "R1 irq idle");
        // R2, R3 load interval via reload bit
        wr(2'd1, 32'd5);
        exp_rd(2'd1, 32'd5, "R2 interval readback");
        wr(2'd0, 32'h7);
        exp_rd(2'd2, 32'd5, "R3 reload loads interval");
        exp_rd(2'd0, 32'h7, "R2 ctrl readback");
        // R4 source select, R8 decrement
        pulse(1, 2);
        exp_rd(2'd2, 32'd3, "R8 decrement on source 1");
        pulse(0, 1); pulse(2, 1);
        exp_rd(2'd2, 32'd3, "R4 unselected sources ignored");
        // R8 underflow
        pulse(1, 3);
        exp_rd(2'd2, 32'd0, "R8 reach zero");
        exp_irq(0, "R8 no irq before underflow");
        pulse(1, 1);
        exp_rd(2'd2, 32'd5, "R8 reload after underflow");
        exp_irq(1, "R8 single irq pulse");
        // R7 enable clear holds count
        wr(2'd0, 32'h4);
        pulse(1, 2);
        exp_rd(2'd2, 32'd5, "R7 disabled holds count");
        // R5 divide by 4 on source 0
        wr(2'd0, 32'h23);
        pulse(0, 3);
        exp_rd(2'd2, 32'd5, "R5 div4 holds for 3 ticks");
        pulse(0, 1);
        exp_rd(2'd2, 32'd4, "R5 div4 fourth tick");
        // R6 control write restarts the prescaler
        pulse(0, 2);
        wr(2'd0, 32'h21);
        exp_rd(2'd2, 32'd4, "R6 no reload without bit1");
        pulse(0, 3);
        exp_rd(2'd2, 32'd4, "R6 prescaler cleared, 3 ticks");
        pulse(0, 1);
        exp_rd(2'd2, 32'd3, "R6 full period after clear");
        // R5 divide by 128 on source 2
        wr(2'd0, 32'h79);
        pulse(2, 127);
        exp_rd(2'd2, 32'd3, "R5 div128 127 ticks");
        pulse(2, 1);
        exp_rd(2'd2, 32'd2, "R5 div128 128th tick");
        // R2 count register is read-only
        wr(2'd2, 32'd99);
        exp_rd(2'd2, 32'd2, "R2 count write ignored");
        // R9 undefined source
        wr(2'd0, 32'h0D);
        pulse(0, 1); pulse(1, 1); pulse(2, 1);
        exp_rd(2'd2, 32'd2, "R9 source 3 frozen");
        exp_rd(2'd3, 32'd1, "R9 err set");
        wr(2'd0, 32'h05);
        exp_rd(2'd3, 32'd1, "R9 err sticky");
        wr(2'd3, 32'd1);
        exp_rd(2'd3, 32'd0, "R9 err cleared");
        pulse(1, 1);
        exp_rd(2'd2, 32'd1, "R4 source 1 resumes");
        exp_irq(1, "R8 irq count unchanged");
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule